// File: doc/BRIEF.md
# Three-Digit Sequential Combination Lock

This block is a clocked lock controller that watches a stream of 4-bit code values, each marked by a one-cycle strobe. It opens only when three strobed values arrive that match a fixed combination in the right order. A first mismatch at any position drops it into a sticky error state. In that state further digits are ignored until reset.

Internally a datapath keeps the three combination values and selects the one expected at the current position through a one-hot multiplexer. An equality comparator then checks the incoming value against it. A five-state controller drives the multiplexer select. Its state encoding is chosen so that the select is simply the low three state bits, and the open output is simply the top state bit. The combination is set by module parameters (default 3, 4, 2). The strobe is expected to be one cycle long per keypress, so a held value is never counted twice.

Top module: `combo_lock`

## Requirements
- R1: While rst_ni is low, the controller is forced to the first-digit state and open_o is 0, whatever state it was in before.
- R2: When the strobed values 3, 4 and 2 arrive in that order with new_i high, open_o rises on the clock edge that samples the third value.
- R3: On a cycle with new_i low in any of the three digit states, the state does not change, so any number of idle cycles between digits still allows the lock to open.
- R4: A strobed value that differs from the expected digit in any of the three positions sends the controller straight to the error state on that edge.
- R5: Once open, open_o stays 1 until reset, whatever the values and strobes.
- R6: The error state keeps open_o at 0 until reset, even if the full correct combination is entered afterwards.
- R7: open_o is 1 only in the open state. The state is held as S1=0001, S2=0010, S3=0100, OPEN=1000, ERR=0000, so at most one bit is ever set.
- R8: The expected-digit select is one-hot (001, 010 and 100 for the first, second and third digit) and equals the low three bits of the state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| value_i | input | 4 | Code value being entered |
| new_i | input | 1 | One-cycle strobe marking a fresh value |
| open_o | output | 1 | 1 when the lock is open |

## Verification
The assertions check on every cycle the properties that depend only on the state: the state is legal (one-hot or zero), OPEN and ERR are sticky, an idle cycle holds the state, a strobed mismatch leads to ERR, open can rise only after a matching third digit, and the select is one-hot. Two things can only be shown by the bench scenarios. The first is that the stored combination is 3, 4, 2 in that order. The second is the end-to-end result of mixed sequences, for example idle gaps, a wrong digit at each position, and reset out of OPEN and ERR, including resets that arrive partway through an entry.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  localparam int ST_W   = 4;
  localparam int SEL_W  = 3;
  localparam int DIGITS = 3;

  // low three bits double as the code select, msb is the open flag
  typedef enum logic [ST_W-1:0] {
    ST_S1   = 4'b0001,
    ST_S2   = 4'b0010,
    ST_S3   = 4'b0100,
    ST_OPEN = 4'b1000,
    ST_ERR  = 4'b0000
  } lock_st_e;
endpackage

// File: rtl/combo_code_path.sv
module combo_code_path
  import combo_lock_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] CODE_A = 4'd3,
  parameter logic [CODE_W-1:0] CODE_B = 4'd4,
  parameter logic [CODE_W-1:0] CODE_C = 4'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [CODE_W-1:0] value_i,
  output logic              match_o
);
  logic [CODE_W-1:0] code_tab [DIGITS];
  logic [CODE_W-1:0] pick [DIGITS];
  logic [CODE_W-1:0] expect_code;

  assign code_tab[0] = CODE_A;
  assign code_tab[1] = CODE_B;
  assign code_tab[2] = CODE_C;

  // and-or mux over one-hot select
  for (genvar i = 0; i < DIGITS; i++) begin : g_pick
    assign pick[i] = code_tab[i] & {CODE_W{sel_i[i]}};
  end

  always_comb begin
    expect_code = '0;
    for (int i = 0; i < DIGITS; i++) expect_code |= pick[i];
  end

  assign match_o = (sel_i != '0) && (value_i == expect_code);

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i)); // R8
endmodule

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm
  import combo_lock_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             new_i,
  input  logic             match_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             open_o
);
  lock_st_e st_q, st_d;
  logic     digit_st;

  assign digit_st = (st_q == ST_S1) || (st_q == ST_S2) || (st_q == ST_S3);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_S1:   if (new_i) st_d = match_i ? ST_S2   : ST_ERR;
      ST_S2:   if (new_i) st_d = match_i ? ST_S3   : ST_ERR;
      ST_S3:   if (new_i) st_d = match_i ? ST_OPEN : ST_ERR;
      ST_OPEN: st_d = ST_OPEN;
      ST_ERR:  st_d = ST_ERR;
      default: st_d = ST_ERR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_S1;
    else         st_q <= st_d;
  end

  assign sel_o  = st_q[SEL_W-1:0];
  assign open_o = st_q[ST_W-1];

  AST_ST_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(st_q)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_st && !new_i) |=> $stable(st_q)); // R3
  AST_MISS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_st && new_i && !match_i) |=> (st_q == ST_ERR)); // R4
  AST_OPEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |=> open_o); // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ERR) |=> (st_q == ST_ERR)); // R6
  AST_OPEN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(new_i && match_i && sel_o == 3'b100)); // R2
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import combo_lock_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] CODE_A = 4'd3,
  parameter logic [CODE_W-1:0] CODE_B = 4'd4,
  parameter logic [CODE_W-1:0] CODE_C = 4'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] value_i,
  input  logic              new_i,
  output logic              open_o
);
  logic [SEL_W-1:0] sel;
  logic             match;

  combo_code_path #(
    .CODE_W(CODE_W), .CODE_A(CODE_A), .CODE_B(CODE_B), .CODE_C(CODE_C)
  ) u_path (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel),
    .value_i (value_i),
    .match_o (match)
  );

  combo_lock_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .new_i   (new_i),
    .match_i (match),
    .sel_o   (sel),
    .open_o  (open_o)
  );

  AST_SEL_TRACKS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |-> (sel == '0)); // R8
endmodule

// File: tb/combo_lock_test.sv
module combo_lock_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] value = '0;
  logic       nw = 1'b0;
  logic       open_w;

  int n_tests = 0;
  int n_fail  = 0;
  int pos     = 0; // 0..2 digit index, 3 open, 4 error
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  combo_lock uut (
    .clk_i(clk), .rst_ni(rst_n), .value_i(value), .new_i(nw), .open_o(open_w)
  );

  function automatic logic [3:0] code_at(int p);
    case (p)
      0: return 4'd3;
      1: return 4'd4;
      default: return 4'd2;
    endcase
  endfunction

  function automatic int model_next(int p, bit r, bit n, logic [3:0] v);
    if (r) return 0;
    if (p < 3 && n) return (v == code_at(p)) ? p + 1 : 4;
    return p;
  endfunction

  task automatic check(string tag);
    logic exp;
    exp = (pos == 3);
    n_tests++;
    if (open_w !== exp) begin
      n_fail++;
      $display("FAIL %s open_o=%0b expected=%0b", tag, open_w, exp);
    end
  endtask

  // drive at negedge, one edge later compare
  task automatic step(bit r, bit n, logic [3:0] v, string tag);
    rst_n = !r;
    nw    = n;
    value = v;
    @(negedge clk);
    pos = model_next(pos, r, n, v);
    check(tag);
    nw = 1'b0;
  endtask

  task automatic enter(logic [3:0] a, logic [3:0] b, logic [3:0] c, int gap, string tag);
    step(0, 1, a, tag);
    for (int i = 0; i < gap; i++) step(0, 0, 4'hF, tag);
    step(0, 1, b, tag);
    for (int i = 0; i < gap; i++) step(0, 0, 4'hF, tag);
    step(0, 1, c, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    step(1, 0, 4'd0, "R1_reset");
    step(1, 0, 4'd0, "R1_reset");

    enter(4'd3, 4'd4, 4'd2, 0, "R2_correct");
    step(0, 1, 4'd9, "R5_open_sticky");
    step(0, 1, 4'd3, "R5_open_sticky");
    step(0, 0, 4'd0, "R5_open_sticky");
    step(1, 0, 4'd0, "R1_reset_from_open");

    enter(4'd3, 4'd4, 4'd2, 5, "R3_idle_gaps");
    step(1, 0, 4'd0, "R1_reset");

    enter(4'd1, 4'd4, 4'd2, 0, "R4_wrong_first");
    enter(4'd3, 4'd4, 4'd2, 0, "R6_err_sticky");
    step(1, 0, 4'd0, "R1_reset_from_err");
    enter(4'd3, 4'd5, 4'd2, 0, "R4_wrong_second");
    step(1, 0, 4'd0, "R1_reset");
    enter(4'd3, 4'd4, 4'd3, 0, "R4_wrong_third");
    step(0, 1, 4'd2, "R6_err_sticky");
    step(1, 0, 4'd0, "R1_reset");

    // right digits in the wrong order
    enter(4'd2, 4'd4, 4'd3, 0, "R8_select_order");
    step(1, 0, 4'd0, "R1_reset");
    // held value: same digit strobed twice must not count as one
    enter(4'd3, 4'd3, 4'd4, 0, "R8_select_order");
    step(1, 0, 4'd0, "R1_reset");
    // reset mid-entry restarts from first digit
    step(0, 1, 4'd3, "R1_mid_entry");
    step(0, 1, 4'd4, "R1_mid_entry");
    step(1, 0, 4'd0, "R1_mid_entry");
    enter(4'd3, 4'd4, 4'd2, 1, "R7_open_only_in_open");

    for (int i = 0; i < 3000; i++) begin
      bit r, n;
      logic [3:0] v;
      r = ($urandom % 20) == 0;
      n = ($urandom % 3) != 0;
      if (($urandom % 10) < 7 && pos < 3) v = code_at(pos);
      else v = 4'($urandom);
      step(r, n, v, "R7_random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule